// File: doc/BRIEF.md
# Coprocessor Host Register Port

This block is the host-side window into an attached I/O coprocessor. The host sees four byte-wide registers. Two of them hold the halves of a 16-bit pointer into the coprocessor's shared memory, one is a data port that reads or writes the byte under that pointer, and one combines control bits with status bits. When auto-increment is on, the pointer moves forward after every data-port access, so a whole block can be uploaded, downloaded or compared through the one data register.

The control and status register starts and stops the coprocessor and selects pass-through (bypass) operation. It also holds a doorbell that interrupts the coprocessor and two pending flags that the coprocessor raises. The first flag means an outbound transfer finished and the second means an inbound message is waiting. Both flags drive a single host interrupt line. The host reads the register to find the cause and clears a flag by writing a 1 to it.

The coprocessor side is modelled as a few pulse inputs and a write port into a backing store. That write port lets the coprocessor place a liveness byte of 0xFF for the host to test and then clear. Only the low `RAM_AW` bits of the pointer select a byte of the backing store, and the default store is 1 KB.

Top module: `cpif_host_port`

## Requirements
- R1: After reset, the control/status register reads 0x00, both pointer bytes read 0x00, and `host_irq`, `cop_run`, `cop_bypass` and `cop_bell` are low.
- R2: Register select 0 loads and returns pointer bits 7:0, and select 1 loads and returns pointer bits 15:8. Accesses to either pointer register never advance the pointer.
- R3: A write to select 2 stores `host_wdata` at the pointer. A read strobe to select 2 returns the stored byte on `host_rdata` one cycle after the strobe. Any read appears on `host_rdata` one cycle after its strobe and holds until the next read. A read strobe in the same cycle as a write strobe is ignored.
- R4: With auto-increment set, each data-port access adds one to the pointer, and 0xFFFF wraps to 0x0000. With auto-increment clear, the pointer does not change.
- R5: A write to select 3 loads run (bit 0), auto-increment (bit 1) and bypass (bit 2). Run drives `cop_run` and bypass drives `cop_bypass`. Reading select 3 returns {2'b00, pend1, pend0, doorbell, bypass, autoinc, run}.
- R6: Writing 1 to bit 3 of select 3 raises `cop_bell`, and writing 0 to that bit has no effect. A `cop_bell_ack` pulse clears the doorbell. If the host sets it and the acknowledge arrives in the same cycle, the set wins.
- R7: A `cop_pend0_set` pulse sets pending bit 4 and a `cop_pend1_set` pulse sets pending bit 5. `host_irq` is high whenever either pending bit is set.
- R8: Writing 1 to bit 4 or bit 5 of select 3 clears that pending bit, and writing 0 leaves it unchanged. A set pulse in the same cycle as the clear wins.
- R9: A `cop_we` pulse stores `cop_wdata` at `cop_addr`, where the host can read it, for example a 0xFF liveness byte that the host then clears to 0x00. If both sides write the same byte in the same cycle, the host write is kept.
- R10: The backing store decodes only the low `RAM_AW` bits of the pointer, so with the default of 10 bits, pointers 0xFFFF and 0x03FF select the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| host_irq | output | 1 | Merged host interrupt |
| cop_pend0_set | input | 1 | Coprocessor pulse: outbound transfer complete |
| cop_pend1_set | input | 1 | Coprocessor pulse: inbound message waiting |
| cop_bell_ack | input | 1 | Coprocessor acknowledges the doorbell |
| cop_we | input | 1 | Coprocessor write strobe into the backing store |
| cop_addr | input | RAM_AW | Coprocessor write address |
| cop_wdata | input | 8 | Coprocessor write byte |
| cop_run | output | 1 | Run enable to the coprocessor |
| cop_bypass | output | 1 | Bypass mode select |
| cop_bell | output | 1 | Doorbell interrupt to the coprocessor |

## Verification
A pointer that is wrong by one shows up at the next data-port read, either as a byte from the neighbouring location or as a pointer-byte readback that differs from the expected count. The bench reads the pointer back after block transfers and after a wrap to catch this. A stuck or lost pending bit or doorbell is visible on `host_irq` or `cop_bell` in the cycle after the event. The status readback then confirms which bit is at fault. Same-cycle set/clear collisions are driven on purpose, because a wrong priority only shows up as a missed or spurious interrupt in exactly that cycle.

// File: rtl/cpif_pkg.sv
package cpif_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CB_RUN     = 0;
  localparam int CB_AUTOINC = 1;
  localparam int CB_BYPASS  = 2;
  localparam int CB_BELL    = 3;
  localparam int CB_PEND0   = 4;
  localparam int CB_PEND1   = 5;
  localparam int CB_W       = 6;
  localparam int NUM_PEND   = 2;

  typedef struct packed {
    logic [NUM_PEND-1:0] pend;
    logic                bell;
    logic                bypass;
    logic                autoinc;
    logic                run;
  } ctrl_t;

endpackage

// File: rtl/cpif_addr_ptr.sv
module cpif_addr_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    wbyte,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam int HI_W = AW - 8;

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ld_lo) begin
      ptr_d[7:0] = wbyte;
    end else if (ld_hi) begin
      ptr_d[AW-1:8] = wbyte[HI_W-1:0];
    end else if (step) begin
      ptr_d = ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld_lo || ld_hi || step) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lo && !ld_hi) |=> (ptr_q == $past(ptr_q) + AW'(1)));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_lo && !ld_hi) |=> $stable(ptr_q));

endmodule

// File: rtl/cpif_ctrl_regs.sv
module cpif_ctrl_regs
  import cpif_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic [CB_W-1:0]     wbits,
  input  logic [NUM_PEND-1:0] pend_set,
  input  logic                bell_ack,
  output ctrl_t               ctrl
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run     = wbits[CB_RUN];
      ctrl_d.autoinc = wbits[CB_AUTOINC];
      ctrl_d.bypass  = wbits[CB_BYPASS];
    end
    ctrl_d.bell = (wr_ctrl && wbits[CB_BELL]) || (ctrl_q.bell && !bell_ack);
    for (int i = 0; i < NUM_PEND; i++) begin
      ctrl_d.pend[i] = pend_set[i] ||
                       (ctrl_q.pend[i] && !(wr_ctrl && wbits[CB_PEND0+i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  for (genvar g = 0; g < NUM_PEND; g++) begin : g_pend_chk
    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set[g] |=> ctrl_q.pend[g]);
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wbits[CB_PEND0+g] && !pend_set[g]) |=> !ctrl_q.pend[g]);
    assert_pend_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.pend[g] && !(wr_ctrl && wbits[CB_PEND0+g])) |=> ctrl_q.pend[g]);
  end

  assert_bell_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_ack && !(wr_ctrl && wbits[CB_BELL])) |=> !ctrl_q.bell);

  assert_bell_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wbits[CB_BELL]) |=> ctrl_q.bell);

endmodule

// File: rtl/cpif_shared_ram.sv
module cpif_shared_ram #(
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [RAM_AW-1:0] h_addr,
  input  logic [7:0]        h_wdata,
  input  logic              c_we,
  input  logic [RAM_AW-1:0] c_addr,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        rd_byte
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [7:0] mem [DEPTH];

  // Coprocessor write first, host write second: the host wins a collision.
  always_ff @(posedge clk) begin
    if (c_we) begin
      mem[c_addr] <= c_wdata;
    end
    if (h_we) begin
      mem[h_addr] <= h_wdata;
    end
  end

  assign rd_byte = mem[h_addr];

  assert_host_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    h_we |=> (mem[$past(h_addr)] == $past(h_wdata)));

  assert_cop_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && !(h_we && h_addr == c_addr)) |=> (mem[$past(c_addr)] == $past(c_wdata)));

endmodule

// File: rtl/cpif_host_port.sv
module cpif_host_port
  import cpif_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_irq,
  input  logic              cop_pend0_set,
  input  logic              cop_pend1_set,
  input  logic              cop_bell_ack,
  input  logic              cop_we,
  input  logic [RAM_AW-1:0] cop_addr,
  input  logic [7:0]        cop_wdata,
  output logic              cop_run,
  output logic              cop_bypass,
  output logic              cop_bell
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  reg_sel_e      sel;
  logic          acc_rd, data_acc, step;
  logic          wr_lo, wr_hi, wr_data, wr_ctrl;
  logic [AW-1:0] ptr;
  logic [7:0]    ram_byte;
  ctrl_t         ctrl;
  logic [7:0]    rdata_q, rdata_d;

  always_comb begin
    sel      = reg_sel_e'(host_sel);
    acc_rd   = host_rd && !host_wr;
    wr_lo    = host_wr && (sel == SEL_PTR_LO);
    wr_hi    = host_wr && (sel == SEL_PTR_HI);
    wr_data  = host_wr && (sel == SEL_DATA);
    wr_ctrl  = host_wr && (sel == SEL_CTRL);
    data_acc = (host_wr || acc_rd) && (sel == SEL_DATA);
    step     = data_acc && ctrl.autoinc;
  end

  cpif_addr_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ld_lo (wr_lo),
    .ld_hi (wr_hi),
    .wbyte (host_wdata),
    .step  (step),
    .ptr   (ptr)
  );

  cpif_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_ctrl  (wr_ctrl),
    .wbits    (host_wdata[CB_W-1:0]),
    .pend_set ({cop_pend1_set, cop_pend0_set}),
    .bell_ack (cop_bell_ack),
    .ctrl     (ctrl)
  );

  cpif_shared_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .h_we    (wr_data),
    .h_addr  (ptr[RAM_AW-1:0]),
    .h_wdata (host_wdata),
    .c_we    (cop_we),
    .c_addr  (cop_addr),
    .c_wdata (cop_wdata),
    .rd_byte (ram_byte)
  );

  always_comb begin
    unique case (sel)
      SEL_PTR_LO: rdata_d = ptr[7:0];
      SEL_PTR_HI: rdata_d = 8'(ptr[AW-1:8]);
      SEL_DATA:   rdata_d = ram_byte;
      default:    rdata_d = 8'(ctrl);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
    end else if (acc_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign host_irq   = |ctrl.pend;
  assign cop_run    = ctrl.run;
  assign cop_bypass = ctrl.bypass;
  assign cop_bell   = ctrl.bell;

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !acc_rd |=> $stable(host_rdata));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cop_pend0_set || cop_pend1_set) |=> host_irq);

endmodule

// File: tb/cpif_host_port_tb_top.sv
module cpif_host_port_tb_top;
  localparam int CLK_NS = 8;
  localparam int RAM_AW = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        host_sel = '0;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              host_irq;
  logic              cop_pend0_set = 1'b0;
  logic              cop_pend1_set = 1'b0;
  logic              cop_bell_ack = 1'b0;
  logic              cop_we = 1'b0;
  logic [RAM_AW-1:0] cop_addr = '0;
  logic [7:0]        cop_wdata = '0;
  logic              cop_run, cop_bypass, cop_bell;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  cpif_host_port #(.AW(16), .RAM_AW(RAM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .cop_pend0_set(cop_pend0_set), .cop_pend1_set(cop_pend1_set),
    .cop_bell_ack(cop_bell_ack), .cop_we(cop_we), .cop_addr(cop_addr),
    .cop_wdata(cop_wdata), .cop_run(cop_run), .cop_bypass(cop_bypass),
    .cop_bell(cop_bell)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    reg_wr(2'd0, p[7:0]);
    reg_wr(2'd1, p[15:8]);
  endtask

  // Monitor: a read strobe seen at an edge yields its byte on host_rdata after that edge.
  initial begin
    forever begin
      @(posedge clk);
      if (host_rd && !host_wr) begin
        #2;
        if (exp_q.size() == 0) begin
          check("R3 unexpected read", host_rdata, 8'h00);
        end else begin
          check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'd0, host_irq}, 8'h00);
    check("R1 run", {7'd0, cop_run}, 8'h00);
    check("R1 bypass", {7'd0, cop_bypass}, 8'h00);
    check("R1 bell", {7'd0, cop_bell}, 8'h00);
    reg_rd(2'd3, 8'h00, "R1 status");
    reg_rd(2'd0, 8'h00, "R1 ptr lo");
    reg_rd(2'd1, 8'h00, "R1 ptr hi");

    // R2 pointer load and readback without advancing
    set_ptr(16'h1234);
    reg_rd(2'd0, 8'h34, "R2 ptr lo");
    reg_rd(2'd1, 8'h12, "R2 ptr hi");
    reg_rd(2'd0, 8'h34, "R2 ptr lo again");

    // R3 data write/read, R4 no advance without auto-increment
    reg_wr(2'd2, 8'hA5);
    reg_rd(2'd2, 8'hA5, "R3 data read");
    reg_rd(2'd0, 8'h34, "R4 ptr held without autoinc");

    // R5 control load, R4 block transfer with auto-increment
    reg_wr(2'd3, 8'h03);
    check("R5 run", {7'd0, cop_run}, 8'h01);
    reg_rd(2'd3, 8'h03, "R5 status");
    set_ptr(16'h0100);
    reg_wr(2'd2, 8'h11);
    reg_wr(2'd2, 8'h22);
    reg_wr(2'd2, 8'h33);
    reg_rd(2'd0, 8'h03, "R4 ptr after block write");
    set_ptr(16'h0100);
    reg_rd(2'd2, 8'h11, "R4 block read 0");
    reg_rd(2'd2, 8'h22, "R4 block read 1");
    reg_rd(2'd2, 8'h33, "R4 block read 2");
    reg_rd(2'd0, 8'h03, "R4 ptr after block read");

    // R4 wrap, R10 aliasing
    set_ptr(16'hFFFF);
    reg_wr(2'd2, 8'h5E);
    reg_rd(2'd0, 8'h00, "R4 wrap lo");
    reg_rd(2'd1, 8'h00, "R4 wrap hi");
    set_ptr(16'h03FF);
    reg_rd(2'd2, 8'h5E, "R10 alias 0xFFFF->0x03FF");
    set_ptr(16'h0234);
    reg_rd(2'd2, 8'hA5, "R10 alias 0x1234->0x0234");

    // R5 bypass, R6 doorbell
    reg_wr(2'd3, 8'h07);
    check("R5 bypass", {7'd0, cop_bypass}, 8'h01);
    reg_wr(2'd3, 8'h0B);
    check("R5 bypass cleared", {7'd0, cop_bypass}, 8'h00);
    check("R6 bell set", {7'd0, cop_bell}, 8'h01);
    reg_wr(2'd3, 8'h03);
    check("R6 bell kept on write 0", {7'd0, cop_bell}, 8'h01);
    reg_rd(2'd3, 8'h0B, "R6 status with bell");
    @(negedge clk); cop_bell_ack = 1'b1;
    @(negedge clk); cop_bell_ack = 1'b0;
    check("R6 bell acked", {7'd0, cop_bell}, 8'h00);
    @(negedge clk);
    host_sel = 2'd3; host_wdata = 8'h0B; host_wr = 1'b1; cop_bell_ack = 1'b1;
    @(negedge clk); host_wr = 1'b0; cop_bell_ack = 1'b0;
    check("R6 set wins over ack", {7'd0, cop_bell}, 8'h01);
    @(negedge clk); cop_bell_ack = 1'b1;
    @(negedge clk); cop_bell_ack = 1'b0;

    // R7 pending bits and merged line, R8 write-1-to-clear
    @(negedge clk); cop_pend0_set = 1'b1;
    @(negedge clk); cop_pend0_set = 1'b0;
    check("R7 irq from pend0", {7'd0, host_irq}, 8'h01);
    reg_rd(2'd3, 8'h13, "R7 status pend0");
    @(negedge clk); cop_pend1_set = 1'b1;
    @(negedge clk); cop_pend1_set = 1'b0;
    reg_rd(2'd3, 8'h33, "R7 status both");
    reg_wr(2'd3, 8'h13);
    reg_rd(2'd3, 8'h23, "R8 pend0 cleared");
    check("R7 irq from pend1", {7'd0, host_irq}, 8'h01);
    reg_wr(2'd3, 8'h03);
    reg_rd(2'd3, 8'h23, "R8 write 0 keeps pend1");
    reg_wr(2'd3, 8'h23);
    reg_rd(2'd3, 8'h03, "R8 pend1 cleared");
    check("R7 irq low", {7'd0, host_irq}, 8'h00);
    @(negedge clk);
    host_sel = 2'd3; host_wdata = 8'h13; host_wr = 1'b1; cop_pend0_set = 1'b1;
    @(negedge clk); host_wr = 1'b0; cop_pend0_set = 1'b0;
    reg_rd(2'd3, 8'h13, "R8 set wins over clear");
    reg_wr(2'd3, 8'h13);

    // R9 coprocessor writes, liveness byte, collision
    @(negedge clk); cop_we = 1'b1; cop_addr = 10'h010; cop_wdata = 8'hFF;
    @(negedge clk); cop_we = 1'b0;
    set_ptr(16'h0010);
    reg_rd(2'd2, 8'hFF, "R9 liveness byte");
    set_ptr(16'h0010);
    reg_wr(2'd2, 8'h00);
    set_ptr(16'h0010);
    reg_rd(2'd2, 8'h00, "R9 liveness cleared");
    set_ptr(16'h0020);
    @(negedge clk);
    host_sel = 2'd2; host_wdata = 8'h77; host_wr = 1'b1;
    cop_we = 1'b1; cop_addr = 10'h020; cop_wdata = 8'h99;
    @(negedge clk); host_wr = 1'b0; cop_we = 1'b0;
    set_ptr(16'h0020);
    reg_rd(2'd2, 8'h77, "R9 host wins collision");

    // R3 read strobe ignored during write
    set_ptr(16'h0040);
    @(negedge clk);
    host_sel = 2'd2; host_wdata = 8'h3C; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b0;
    check("R3 rdata held on rd+wr", host_rdata, 8'h77);
    reg_rd(2'd0, 8'h41, "R3 single advance on rd+wr");
    set_ptr(16'h0040);
    reg_rd(2'd2, 8'h3C, "R3 write landed on rd+wr");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3 pending reads: actual %0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule